// File: doc/BRIEF.md
# Pin Event Counter with Edge Capture Flags

This block observes an 8-bit port of external input pins. It keeps a latched copy of the port, updated whenever a new pin value is presented. One pin (bit 7 by default) can feed an 8-bit event counter. The counter advances on a chosen edge of that pin. It does so only when the pin is configured as an input and the counter is enabled in event-counting mode. When the counter wraps to zero it raises an overflow flag.

The low pins (bits 2, 1 and 0 by default) each feed a capture channel. Each channel has a two-bit edge selector. On a matching transition the channel sets a sticky flag and pulses a one-cycle strobe that names the capture unit. A timer elsewhere can use this strobe to latch its count.

Flags are cleared by write-one strobes. A single interrupt request combines each flag with its enable. The control bits arrive as plain inputs from the register file that owns them.

Top module: `pin_event_counter`

## Requirements
- R1: On a cycle with `pin_wr` high, `port_q` takes `pin_in`, except that bit 7 keeps its old value while `pa_dir_out` is 1; the new value is visible after that clock edge.
- R2: `pa_count` changes only on a write where `pa_en` is 1 and `pa_gated` is 0.
- R3: With `pa_rise` = 1 the counter advances when port bit 7 goes from 0 to 1; with `pa_rise` = 0 it advances when bit 7 goes from 1 to 0; a write that leaves bit 7 unchanged never counts.
- R4: Each qualifying write adds exactly one to the 8-bit `pa_count`, modulo 256.
- R5: An increment from 255 to 0 sets `ovf_flag`.
- R6: Capture channel i watches port bit i with selector `cap_edge[2i+1:2i]`: 01 rising only, 10 falling only, 11 both edges; only a bit that actually changed counts.
- R7: A capture on channel i sets `cap_flag[i]` and drives `cap_evt[2-i]` high for exactly one cycle (bit k of `cap_evt` denotes capture unit k+1).
- R8: Selector 00 disables a channel: no flag and no strobe, whatever the pin does.
- R9: A 1 on `cap_clr[i]` clears `cap_flag[i]`, and `ovf_clr` clears `ovf_flag`; when a set and a clear meet in one cycle, the flag ends set.
- R10: `irq` is 1 exactly when some `cap_flag[i]` with `cap_ie[i]` = 1 is set, or `ovf_flag` is set with `ovf_ie` = 1; it follows the flags with no added register.
- R11: After reset, port copy, counter, flags, strobes and `irq` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_wr | input | 1 | New pin value present on `pin_in` |
| pin_in | input | 8 | External pin values |
| pa_dir_out | input | 1 | 1: bit 7 is an output and is not taken from `pin_in` |
| pa_en | input | 1 | Counter enable |
| pa_gated | input | 1 | 1: gated mode, event counting suspended |
| pa_rise | input | 1 | Counting edge: 1 rising, 0 falling |
| cap_edge | input | 6 | Two-bit edge selector per capture channel |
| cap_clr | input | 3 | Write-one clear of the capture flags |
| ovf_clr | input | 1 | Write-one clear of the overflow flag |
| cap_ie | input | 3 | Interrupt enable per capture flag |
| ovf_ie | input | 1 | Interrupt enable for overflow |
| port_q | output | 8 | Latched port value |
| pa_count | output | 8 | Event counter |
| cap_flag | output | 3 | Sticky capture flags |
| ovf_flag | output | 1 | Sticky overflow flag |
| cap_evt | output | 3 | One-cycle capture strobe, bit k = unit k+1 |
| irq | output | 1 | Interrupt request |

## Verification
Every registered result (port copy, counter, flags and strobes) is due at the first rising edge that samples `pin_wr` or a clear strobe high. The strobe drops again one cycle later. `irq` follows the flags combinationally, in the same cycle. The bench drives stimulus on the falling edge and holds it through one rising edge. It compares all outputs at the next falling edge against its own model. A further idle cycle confirms that the strobes have returned to zero.

// File: rtl/pec_pkg.sv
package pec_pkg;
   typedef enum logic [1:0] {
      EDGE_OFF  = 2'b00,
      EDGE_RISE = 2'b01,
      EDGE_FALL = 2'b10,
      EDGE_BOTH = 2'b11
   } edge_sel_e;

   function automatic logic edge_match(input logic [1:0] sel,
                                       input logic       prev,
                                       input logic       nxt);
      edge_match = (prev != nxt) && ((sel[0] && nxt) || (sel[1] && !nxt));
   endfunction
endpackage

// File: rtl/pec_port_latch.sv
module pec_port_latch #(
   parameter int W        = 8,
   parameter int HOLD_BIT = 7
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr,
   input  logic [W-1:0] wdata,
   input  logic         hold,
   output logic [W-1:0] port_q,
   output logic [W-1:0] port_nxt
);
   localparam logic [W-1:0] HOLD_MASK = W'(1) << HOLD_BIT;

   logic [W-1:0] take_mask;

   assign take_mask = hold ? ~HOLD_MASK : '1;
   assign port_nxt  = (wdata & take_mask) | (port_q & ~take_mask);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  port_q <= '0;
      else if (wr) port_q <= port_nxt;
   end

   assert_held_bit_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && hold) |=> (port_q[HOLD_BIT] == $past(port_q[HOLD_BIT])));
endmodule

// File: rtl/pec_pulse_acc.sv
module pec_pulse_acc #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             step,
   input  logic             prev_bit,
   input  logic             next_bit,
   input  logic             en,
   input  logic             gated,
   input  logic             edge_hi,
   input  logic             ovf_clr,
   output logic [CNT_W-1:0] count,
   output logic             ovf
);
   logic inc, wrap;

   assign inc  = step && en && !gated && (prev_bit != next_bit) && (next_bit == edge_hi);
   assign wrap = inc && (count == '1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count <= '0;
         ovf   <= 1'b0;
      end else begin
         if (inc) count <= count + 1'b1;
         if (wrap)         ovf <= 1'b1;
         else if (ovf_clr) ovf <= 1'b0;
      end
   end

   assert_count_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (count != $past(count)) |-> $past(en && !gated && step));
   assert_count_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (count != $past(count)) |-> (count == CNT_W'($past(count) + 1'b1)));
   assert_ovf_at_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ovf) |-> (count == '0));
endmodule

// File: rtl/pec_edge_chan.sv
module pec_edge_chan
   import pec_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       step,
   input  logic [1:0] sel,
   input  logic       prev,
   input  logic       nxt,
   input  logic       clr,
   output logic       flag,
   output logic       strobe
);
   logic hit;

   assign hit = step && edge_match(sel, prev, nxt);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag   <= 1'b0;
         strobe <= 1'b0;
      end else begin
         strobe <= hit;
         if (hit)      flag <= 1'b1;
         else if (clr) flag <= 1'b0;
      end
   end

   assert_strobe_sets_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
      strobe |-> flag);
   assert_off_no_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
      strobe |-> (edge_sel_e'($past(sel)) != EDGE_OFF));
   assert_clear_works_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && !step) |=> !flag);
endmodule

// File: rtl/pin_event_counter.sv
module pin_event_counter #(
   parameter int PORT_W = 8,
   parameter int PA_BIT = 7,
   parameter int CNT_W  = 8,
   parameter int N_CAP  = 3
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 pin_wr,
   input  logic [PORT_W-1:0]    pin_in,
   input  logic                 pa_dir_out,
   input  logic                 pa_en,
   input  logic                 pa_gated,
   input  logic                 pa_rise,
   input  logic [2*N_CAP-1:0]   cap_edge,
   input  logic [N_CAP-1:0]     cap_clr,
   input  logic                 ovf_clr,
   input  logic [N_CAP-1:0]     cap_ie,
   input  logic                 ovf_ie,
   output logic [PORT_W-1:0]    port_q,
   output logic [CNT_W-1:0]     pa_count,
   output logic [N_CAP-1:0]     cap_flag,
   output logic                 ovf_flag,
   output logic [N_CAP-1:0]     cap_evt,
   output logic                 irq
);
   localparam int SEL_W = 2;

   if (PA_BIT >= PORT_W) begin : g_bad_pa
      $error("PA_BIT must address a port bit");
   end
   if (N_CAP >= PA_BIT || N_CAP < 1) begin : g_bad_cap
      $error("capture channels must sit below the counter pin");
   end
   if (CNT_W < 2) begin : g_bad_cnt
      $error("counter too narrow");
   end

   logic [PORT_W-1:0] port_nxt;

   pec_port_latch #(.W(PORT_W), .HOLD_BIT(PA_BIT)) u_latch (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr       (pin_wr),
      .wdata    (pin_in),
      .hold     (pa_dir_out),
      .port_q   (port_q),
      .port_nxt (port_nxt)
   );

   pec_pulse_acc #(.CNT_W(CNT_W)) u_acc (
      .clk      (clk),
      .rst_n    (rst_n),
      .step     (pin_wr),
      .prev_bit (port_q[PA_BIT]),
      .next_bit (port_nxt[PA_BIT]),
      .en       (pa_en),
      .gated    (pa_gated),
      .edge_hi  (pa_rise),
      .ovf_clr  (ovf_clr),
      .count    (pa_count),
      .ovf      (ovf_flag)
   );

   for (genvar i = 0; i < N_CAP; i++) begin : g_chan
      pec_edge_chan u_chan (
         .clk    (clk),
         .rst_n  (rst_n),
         .step   (pin_wr),
         .sel    (cap_edge[SEL_W*i +: SEL_W]),
         .prev   (port_q[i]),
         .nxt    (port_nxt[i]),
         .clr    (cap_clr[i]),
         .flag   (cap_flag[i]),
         .strobe (cap_evt[N_CAP-1-i])
      );
   end

   assign irq = (|(cap_flag & cap_ie)) | (ovf_flag & ovf_ie);

   assert_irq_source_R10: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> ((|cap_flag) || ovf_flag));
   assert_evt_single_cycle_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (|cap_evt && !pin_wr) |=> (cap_evt == '0));
endmodule

// File: tb/tb_pin_event_counter.sv
`timescale 1ns/1ps
module tb_pin_event_counter;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       pin_wr = 1'b0;
   logic [7:0] pin_in = '0;
   logic       pa_dir_out = 1'b0, pa_en = 1'b0, pa_gated = 1'b0, pa_rise = 1'b0;
   logic [5:0] cap_edge = '0;
   logic [2:0] cap_clr = '0;
   logic       ovf_clr = 1'b0;
   logic [2:0] cap_ie = '0;
   logic       ovf_ie = 1'b0;
   logic [7:0] port_q, pa_count;
   logic [2:0] cap_flag, cap_evt;
   logic       ovf_flag, irq;

   int n_chk = 0, n_bad = 0;
   bit done = 0;
   int cyc = 0;

   logic [7:0] m_port = '0, m_cnt = '0;
   logic [2:0] m_cf = '0, m_evt = '0;
   logic       m_ovf = 1'b0;

   pin_event_counter dut (
      .clk(clk), .rst_n(rst_n), .pin_wr(pin_wr), .pin_in(pin_in),
      .pa_dir_out(pa_dir_out), .pa_en(pa_en), .pa_gated(pa_gated), .pa_rise(pa_rise),
      .cap_edge(cap_edge), .cap_clr(cap_clr), .ovf_clr(ovf_clr),
      .cap_ie(cap_ie), .ovf_ie(ovf_ie), .port_q(port_q), .pa_count(pa_count),
      .cap_flag(cap_flag), .ovf_flag(ovf_flag), .cap_evt(cap_evt), .irq(irq));

   always #10 clk = ~clk;

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 150000 && !done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: run did not complete (actual hung, expected finish)");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   function automatic logic exp_irq();
      return (|(m_cf & cap_ie)) | (m_ovf & ovf_ie);
   endfunction

   task automatic check_all();
      chk("R1 port", port_q, m_port);
      chk("R4 count", pa_count, m_cnt);
      chk("R7 flags", {5'b0, cap_flag}, {5'b0, m_cf});
      chk("R7 strobe", {5'b0, cap_evt}, {5'b0, m_evt});
      chk("R5 ovf", {7'b0, ovf_flag}, {7'b0, m_ovf});
      chk("R10 irq", {7'b0, irq}, {7'b0, exp_irq()});
   endtask

   // model of one pin write, with optional clears in the same cycle
   task automatic do_wr(logic [7:0] v, logic [2:0] cc, logic oc);
      logic [7:0] nxt;
      logic [1:0] s;
      logic rise, fall, hit;
      @(negedge clk);
      pin_in = v; pin_wr = 1'b1; cap_clr = cc; ovf_clr = oc;
      nxt = pa_dir_out ? {m_port[7], v[6:0]} : v;
      m_evt = '0;
      m_cf = m_cf & ~cc;
      for (int i = 0; i < 3; i++) begin
         s = cap_edge[2*i +: 2];
         rise = !m_port[i] && nxt[i];
         fall = m_port[i] && !nxt[i];
         case (s)
            2'b01:   hit = rise;
            2'b10:   hit = fall;
            2'b11:   hit = rise || fall;
            default: hit = 1'b0;
         endcase
         if (hit) begin m_cf[i] = 1'b1; m_evt[2-i] = 1'b1; end
      end
      if (oc) m_ovf = 1'b0;
      if (pa_en && !pa_gated && (nxt[7] != m_port[7]) && (nxt[7] == pa_rise)) begin
         if (m_cnt == 8'hFF) m_ovf = 1'b1;
         m_cnt = m_cnt + 8'd1;
      end
      m_port = nxt;
      @(negedge clk);
      pin_wr = 1'b0; cap_clr = '0; ovf_clr = 1'b0;
      check_all();
   endtask

   task automatic do_clr(logic [2:0] cc, logic oc);
      cap_clr = cc; ovf_clr = oc;
      m_cf = m_cf & ~cc;
      if (oc) m_ovf = 1'b0;
      m_evt = '0;
      @(negedge clk);
      cap_clr = '0; ovf_clr = 1'b0;
      check_all();
   endtask

   initial begin
      logic [7:0] s;
      repeat (3) @(negedge clk);
      // R11: reset state
      chk("R11 port", port_q, 8'h00);
      chk("R11 count", pa_count, 8'h00);
      chk("R11 flags", {4'b0, cap_flag, ovf_flag}, 8'h00);
      chk("R11 strobe", {5'b0, cap_evt}, 8'h00);
      chk("R11 irq", {7'b0, irq}, 8'h00);
      rst_n = 1'b1;
      @(negedge clk);

      // R6 R7 R8 R9 R10: sweep of every edge selector combination
      for (int cfg = 0; cfg < 64; cfg++) begin
         cap_edge = 6'(cfg);
         cap_ie = 3'(cfg >> 3) ^ 3'b101;
         ovf_ie = cfg[0];
         pa_en = cfg[1]; pa_rise = cfg[2];
         s = 8'(cfg * 7);
         for (int k = 0; k < 8; k++) begin
            s = 8'(s * 5 + 3);
            do_wr(s, 3'b000, 1'b0);
         end
         do_clr(3'b111, 1'b1);  // R9 clear, also strobe back to zero (R7)
      end

      // R9: set wins over a clear in the same cycle
      cap_edge = 6'b111111; pa_en = 1'b0;
      do_wr(m_port ^ 8'h07, 3'b111, 1'b0);
      chk("R9 set-wins", {5'b0, cap_flag}, 8'h07);
      do_clr(3'b111, 1'b0);

      // R1 R2 R3 R4: counter gating, edge choice and pin direction
      cap_edge = '0;
      for (int c = 0; c < 16; c++) begin
         pa_dir_out = c[0]; pa_en = c[1]; pa_gated = c[2]; pa_rise = c[3];
         for (int k = 0; k < 12; k++) begin
            do_wr(8'(((k % 3) == 2 ? 0 : (k & 1)) << 7 | (k * 9 + c)), 3'b000, 1'b0);
         end
      end

      // R5: wrap of the counter sets overflow; R10 with overflow enable
      pa_dir_out = 1'b0; pa_en = 1'b1; pa_gated = 1'b0; pa_rise = 1'b1; ovf_ie = 1'b1;
      cap_ie = '0;
      do_clr(3'b111, 1'b1);
      for (int k = 0; k < 300 && !m_ovf; k++) begin
         do_wr(8'h00, 3'b000, 1'b0);
         do_wr(8'h80, 3'b000, 1'b0);
      end
      chk("R5 wrap flag", {7'b0, ovf_flag}, 8'h01);
      chk("R5 wrap count", pa_count, 8'h00);
      chk("R10 ovf irq", {7'b0, irq}, 8'h01);
      do_clr(3'b000, 1'b1);
      chk("R9 ovf cleared", {7'b0, ovf_flag}, 8'h00);

      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule